// File: doc/BRIEF.md
# Frame Stream Sequence Checker

This block sits beside a camera packet parser and watches the control tokens the parser sends toward its pixel output. There are five tokens: frame start, line start carrying data, plain data, line end carrying data, and frame end. The checker follows the token sequence with a small state machine. When a token breaks the legal ordering, it sets a sticky stream-error status bit.

Software clears the error bit by writing a one to it. The error drives an interrupt line through a mask bit that resets to zero, which holds the interrupt off. After a violation the checker stops judging tokens until the next frame start, and then resumes checking. A parser disable command puts the checker back into its waiting-for-frame-start state and leaves the status untouched. Each accepted frame start produces a one-cycle pulse.

Top module: `fseq_checker`

## Requirements
- R1: After reset, stat_err, irq and fs_pulse are 0. The checker expects a frame start, and any other first token sets stat_err.
- R2: Token codes on tok_code are 1 = frame start, 2 = line start, 3 = data, 4 = line end and 5 = frame end. Codes 0, 6 and 7 are illegal in every checked state.
- R3: After a frame start, only a line start or a frame end is legal. Any other token sets stat_err one cycle after the token's clock edge.
- R4: After a line start, only data or a line end is legal.
- R5: After data, only a line end is legal.
- R6: After a line end, only a line start or a frame end is legal.
- R7: After a frame end, only a frame start is legal.
- R8: Every accepted frame start raises fs_pulse for exactly one cycle, following the token's edge. A frame start that is itself illegal gives no pulse.
- R9: After a violation, every token other than a frame start is ignored. The next frame start is accepted and checking resumes from it.
- R10: A status write with stat_wdata = 1 clears stat_err, and a write with 0 has no effect. A violation in the same cycle as a clear leaves stat_err set.
- R11: irq is high only while stat_err and the mask bit are both 1. The mask bit is loaded by mask_wr and resets to 0.
- R12: par_disable returns the checker to waiting for a frame start and leaves stat_err unchanged. A token that arrives in the same cycle as par_disable is ignored.
- R13: tok_code has no effect while tok_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_code | input | 3 | Token code |
| par_disable | input | 1 | Parser disable command |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 1 | Status write data (1 clears the error) |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 1 | Mask bit value |
| stat_err | output | 1 | Sticky stream-error status |
| irq | output | 1 | Masked interrupt |
| fs_pulse | output | 1 | Pulse per accepted frame start |

## Verification
Complete frames are sent, including multi-line frames, a line with no data token and an empty frame. None of them may raise the error, and each one shows the frame-start pulse. For every grammar state, a token from outside its legal set is injected, which separates the error decision of one state from that of its neighbours. A garbage stream after an error, a frame start arriving together with a disable, and codes changing while the strobe is low each show whether tokens are wrongly judged or wrongly ignored. A clear that collides with a violation shows whether setting the error takes priority over clearing it.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
  localparam int TOK_W = 3;
  typedef logic [TOK_W-1:0] tok_t;

  localparam tok_t TOK_FS = 3'd1;
  localparam tok_t TOK_LS = 3'd2;
  localparam tok_t TOK_DT = 3'd3;
  localparam tok_t TOK_LE = 3'd4;
  localparam tok_t TOK_FE = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for frame start (also after frame end)
    ST_HUNT = 3'd1,  // after a violation, silent until frame start
    ST_FS   = 3'd2,
    ST_LINE = 3'd3,
    ST_DATA = 3'd4,
    ST_LEND = 3'd5
  } seq_state_e;

  // legal successor set of each state
  function automatic logic tok_legal(seq_state_e s, tok_t t);
    case (s)
      ST_IDLE, ST_HUNT: tok_legal = (t == TOK_FS);
      ST_FS:            tok_legal = (t == TOK_LS) || (t == TOK_FE);
      ST_LINE:          tok_legal = (t == TOK_DT) || (t == TOK_LE);
      ST_DATA:          tok_legal = (t == TOK_LE);
      ST_LEND:          tok_legal = (t == TOK_LS) || (t == TOK_FE);
      default:          tok_legal = 1'b0;
    endcase
  endfunction

  // state reached after a valid token
  function automatic seq_state_e tok_step(seq_state_e s, tok_t t);
    if (!tok_legal(s, t)) begin
      tok_step = ST_HUNT;
    end else begin
      case (t)
        TOK_FS:  tok_step = ST_FS;
        TOK_LS:  tok_step = ST_LINE;
        TOK_DT:  tok_step = ST_DATA;
        TOK_LE:  tok_step = ST_LEND;
        default: tok_step = ST_IDLE;
      endcase
    end
  endfunction
endpackage

// File: rtl/fseq_grammar.sv
`timescale 1ns/1ps
module fseq_grammar
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tok_valid,
  input  tok_t tok_code,
  input  logic flush,
  output logic viol,
  output logic fs_pulse,
  output logic in_hunt
);
  seq_state_e st_q, st_d;
  logic live, legal, fs_acc;

  always_comb begin
    live    = tok_valid && !flush;
    legal   = tok_legal(st_q, tok_code);
    in_hunt = (st_q == ST_HUNT);
    viol    = live && !in_hunt && !legal;
    fs_acc  = live && legal && (tok_code == TOK_FS);
    st_d    = st_q;
    if (flush) begin
      st_d = ST_IDLE;
    end else if (tok_valid) begin
      st_d = tok_step(st_q, tok_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fs_pulse <= 1'b0;
    end else begin
      st_q     <= st_d;
      fs_pulse <= fs_acc;
    end
  end
endmodule

// File: rtl/fseq_status.sv
`timescale 1ns/1ps
module fseq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic mask_wr_i,
  input  logic mask_wdata_i,
  output logic err_o,
  output logic irq_o,
  output logic clr_hit_o
);
  logic err_q, mask_q, err_d;

  always_comb begin
    clr_hit_o = wr_i && wdata_i;
    err_d     = set_i || (err_q && !clr_hit_o);  // set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  assign err_o = err_q;
  assign irq_o = err_q && mask_q;
endmodule

// File: rtl/fseq_checker.sv
`timescale 1ns/1ps
module fseq_checker
  import fseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [TOK_W-1:0] tok_code,
  input  logic             par_disable,
  input  logic             stat_wr,
  input  logic             stat_wdata,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  output logic             stat_err,
  output logic             irq,
  output logic             fs_pulse
);
  logic viol, in_hunt, clr_hit;

  fseq_grammar u_gram (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_valid(tok_valid),
    .tok_code (tok_code),
    .flush    (par_disable),
    .viol     (viol),
    .fs_pulse (fs_pulse),
    .in_hunt  (in_hunt)
  );

  fseq_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (viol),
    .wr_i        (stat_wr),
    .wdata_i     (stat_wdata),
    .mask_wr_i   (mask_wr),
    .mask_wdata_i(mask_wdata),
    .err_o       (stat_err),
    .irq_o       (irq),
    .clr_hit_o   (clr_hit)
  );
endmodule

// File: rtl/fseq_checker_sva.sv
`timescale 1ns/1ps
module fseq_checker_sva
  import fseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tok_valid,
  input logic [TOK_W-1:0] tok_code,
  input logic             par_disable,
  input logic             stat_err,
  input logic             irq,
  input logic             fs_pulse,
  input logic             viol,
  input logic             in_hunt,
  input logic             clr_hit
);
  assert_violation_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> stat_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_err) && !$past(clr_hit) |-> stat_err);

  assert_irq_needs_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_err);

  assert_pulse_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_pulse |-> $past(tok_valid && tok_code == TOK_FS && !par_disable));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_pulse |=> !fs_pulse);

  assert_hunt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_hunt |-> !viol);

  assert_disable_no_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    par_disable |=> !fs_pulse);

  assert_idle_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |-> !viol);
endmodule

bind fseq_checker fseq_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .tok_valid  (tok_valid),
  .tok_code   (tok_code),
  .par_disable(par_disable),
  .stat_err   (stat_err),
  .irq        (irq),
  .fs_pulse   (fs_pulse),
  .viol       (viol),
  .in_hunt    (in_hunt),
  .clr_hit    (clr_hit)
);

// File: tb/fseq_checker_tb.sv
`timescale 1ns/1ps
module fseq_checker_tb;
  localparam logic [2:0] FS = 3'd1, LS = 3'd2, DT = 3'd3, LE = 3'd4, FE = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [2:0] tok_code = 3'd0;
  logic par_disable = 1'b0;
  logic stat_wr = 1'b0, stat_wdata = 1'b0;
  logic mask_wr = 1'b0, mask_wdata = 1'b0;
  logic stat_err, irq, fs_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fseq_checker u_dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_code(tok_code),
    .par_disable(par_disable), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .stat_err(stat_err), .irq(irq), .fs_pulse(fs_pulse)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive one token at a falling edge; outputs are sampled at the next falling edge
  task automatic send(logic [2:0] c);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_code  = c;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    par_disable = 1'b1;
    @(negedge clk);
    par_disable = 1'b0;
  endtask

  task automatic fresh();
    go_idle();
    clear_err();
  endtask

  task automatic t_reset_R1();
    check("R1 err", stat_err, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 pulse", fs_pulse, 1'b0);
    send(LS);
    check("R1 first token not FS", stat_err, 1'b1);
    fresh();
  endtask

  task automatic t_good_frames();
    send(FS); check("R8 pulse", fs_pulse, 1'b1); check("R3 err", stat_err, 1'b0);
    @(negedge clk); check("R8 one cycle", fs_pulse, 1'b0);
    send(LS); send(DT); send(LE); check("R5 err", stat_err, 1'b0);
    send(LS); send(LE); check("R4 empty line", stat_err, 1'b0);
    send(FE); check("R6 err", stat_err, 1'b0);
    send(FS); check("R7 FS after FE", fs_pulse, 1'b1);
    send(FE); check("R3 empty frame", stat_err, 1'b0);
    check("R8 no pulse on FE", fs_pulse, 1'b0);
  endtask

  task automatic t_bad_tokens();
    fresh(); send(FS); send(DT); check("R3 DT after FS", stat_err, 1'b1);
    fresh(); send(FS); send(LS); send(FS);
    check("R4 FS after LS", stat_err, 1'b1);
    check("R8 illegal FS no pulse", fs_pulse, 1'b0);
    fresh(); send(FS); send(LS); send(DT); send(LS); check("R5 LS after DT", stat_err, 1'b1);
    fresh(); send(FS); send(LS); send(DT); send(DT); check("R5 DT after DT", stat_err, 1'b1);
    fresh(); send(FS); send(LS); send(LE); send(DT); check("R6 DT after LE", stat_err, 1'b1);
    fresh(); send(FS); send(FE); send(LS); check("R7 LS after FE", stat_err, 1'b1);
    fresh(); send(FS); send(LS); send(3'd6); check("R2 code 6", stat_err, 1'b1);
    fresh(); send(FS); send(3'd0); check("R2 code 0", stat_err, 1'b1);
    fresh(); send(3'd7); check("R2 code 7 idle", stat_err, 1'b1);
  endtask

  task automatic t_hunt_R9();
    fresh(); send(FS); send(FS);
    clear_err();
    send(DT); send(3'd7); send(LE);
    check("R9 ignored in hunt", stat_err, 1'b0);
    send(FS); check("R9 resync pulse", fs_pulse, 1'b1);
    send(DT); check("R9 checking resumed", stat_err, 1'b1);
  endtask

  task automatic t_w1c_R10();
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b0;
    @(negedge clk); stat_wr = 1'b0;
    check("R10 write 0 keeps", stat_err, 1'b1);
    clear_err(); check("R10 write 1 clears", stat_err, 1'b0);
    go_idle();
    @(negedge clk); tok_valid = 1'b1; tok_code = LS; stat_wr = 1'b1; stat_wdata = 1'b1;
    @(negedge clk); tok_valid = 1'b0; stat_wr = 1'b0; stat_wdata = 1'b0;
    check("R10 set beats clear", stat_err, 1'b1);
  endtask

  task automatic t_irq_R11();
    check("R11 mask reset blocks", irq, 1'b0);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 1'b1;
    @(negedge clk); mask_wr = 1'b0;
    check("R11 unmasked irq", irq, 1'b1);
    clear_err(); check("R11 irq follows clear", irq, 1'b0);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 1'b0;
    @(negedge clk); mask_wr = 1'b0;
    go_idle(); send(DT);
    check("R11 masked err", stat_err, 1'b1);
    check("R11 masked irq", irq, 1'b0);
  endtask

  task automatic t_disable_R12();
    go_idle(); check("R12 status kept", stat_err, 1'b1);
    clear_err();
    send(FS); send(LS);
    go_idle(); check("R12 no error", stat_err, 1'b0);
    send(FS); check("R12 FS after disable", fs_pulse, 1'b1);
    go_idle();
    @(negedge clk); tok_valid = 1'b1; tok_code = FS; par_disable = 1'b1;
    @(negedge clk); tok_valid = 1'b0; par_disable = 1'b0;
    check("R12 token with disable ignored", fs_pulse, 1'b0);
    send(LS); check("R12 still waiting for FS", stat_err, 1'b1);
  endtask

  task automatic t_strobe_R13();
    fresh(); send(FS);
    @(negedge clk); tok_code = DT;
    @(negedge clk); tok_code = 3'd7;
    @(negedge clk); tok_code = FS;
    @(negedge clk);
    check("R13 no err", stat_err, 1'b0);
    check("R13 no pulse", fs_pulse, 1'b0);
    send(LS); check("R13 state unchanged", stat_err, 1'b0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_good_frames();
    t_bad_tokens();
    t_hunt_R9();
    t_w1c_R10();
    t_irq_R11();
    t_disable_R12();
    t_strobe_R13();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    report();
  end
endmodule